// File: doc/BRIEF.md
# Complementary Dead-Band Generator

This block turns one pulse-width-modulated control signal into a pair of gate drive signals for the two switches of a half bridge. Output A is the high-side drive and output B is the low-side drive. Each drive waits a programmable number of clock cycles after its own turn-on edge, so there is always a gap between one switch turning off and the other turning on. The turn-on delay of A and the turn-on delay of B are set separately.

Both outputs are active high and complementary: A can only be on while the source is high, and B can only be on while the source is low. Either output can have its delay switched off. It then follows the source (A) or the inverted source (B), with the same one-cycle register latency. A source pulse that is too short to outlast the delay produces no output pulse at all, so no narrow gate pulses reach the switches.

Top module: `deadband_pair`

## Requirements
- R1: While `rst` is high at a clock edge, both `out_a` and `out_b` are low after that edge.
- R2: With `en_a` high, `out_a` is high after edge n only if `pwm_in` was sampled high at edge n and at each of the `rise_dly` edges before it, counted since reset. A sample of `pwm_in` low drives `out_a` low after that same edge.
- R3: With `en_b` high, `out_b` is high after edge n only if `pwm_in` was sampled low at edge n and at each of the `fall_dly` edges before it, counted since reset. A sample of `pwm_in` high drives `out_b` low after that same edge.
- R4: `out_a` and `out_b` are never high in the same cycle.
- R5: A high pulse of `pwm_in` lasting `rise_dly` cycles or fewer leaves `out_a` low throughout. A low gap lasting `fall_dly` cycles or fewer leaves `out_b` low throughout.
- R6: A delay value of 0 makes the output follow its source one clock edge later. For A the source is `pwm_in`; for B it is the inverse of `pwm_in`.
- R7: With `en_a` low, `out_a` equals the value `pwm_in` had at the previous edge.
- R8: With `en_b` low, `out_b` equals the inverse of the value `pwm_in` had at the previous edge.
- R9: Both delay inputs use their full 14-bit range. A delay of 16383 holds the output off for 16383 cycles of continuous source activity and turns it on at the next one.
- R10: `rise_dly` affects only `out_a` and `fall_dly` affects only `out_b`. Unequal settings give unequal dead times on the two edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pwm_in | input | 1 | Source PWM signal |
| rise_dly | input | 14 | Turn-on delay of `out_a`, in clock cycles |
| fall_dly | input | 14 | Turn-on delay of `out_b`, in clock cycles |
| en_a | input | 1 | Enables the delay on `out_a`; low selects bypass |
| en_b | input | 1 | Enables the delay on `out_b`; low selects bypass |
| out_a | output | 1 | High-side drive, active high |
| out_b | output | 1 | Low-side drive, active high |

## Verification
The assertions take nothing for granted about the shape or timing of `pwm_in`. They do assume that the delay and enable inputs are sampled on the same edge as the source, so a change in a setting applies from that edge on. The stimulus changes settings only away from clock edges, while the source is low. It drives every input on the falling clock edge, and the behavioural model reads the inputs on the rising edge, in the same way the design does. Runt pulses, pulses exactly equal to the delay, zero delays and the largest 14-bit delay are all driven on purpose, so that each edge case falls in a window the model compares.

// File: rtl/deadband_pkg.sv
package deadband_pkg;
  localparam int DB_DLY_W_DEF = 14;
  localparam int DB_NCH       = 2;
  localparam int DB_CH_HI     = 0;
  localparam int DB_CH_LO     = 1;
endpackage

// File: rtl/db_source_split.sv
module db_source_split
  import deadband_pkg::*;
(
  input  logic              pwm_in,
  output logic [DB_NCH-1:0] chan_src
);
  // High side is driven by the source, low side by its complement.
  always_comb begin
    chan_src           = '0;
    chan_src[DB_CH_HI] = pwm_in;
    chan_src[DB_CH_LO] = ~pwm_in;
  end
endmodule

// File: rtl/db_onset_delay.sv
module db_onset_delay #(
  parameter int DLY_W = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             src,
  input  logic [DLY_W-1:0] dly,
  input  logic             en,
  output logic             q
);
  localparam logic [DLY_W-1:0] RUN_MAX = {DLY_W{1'b1}};

  // Number of consecutive earlier samples with src high, saturating.
  logic [DLY_W-1:0] run_len;
  logic             qual;

  assign qual = src && (run_len >= dly);

  always_ff @(posedge clk) begin
    if (rst) begin
      run_len <= '0;
      q       <= 1'b0;
    end else begin
      if (!src)
        run_len <= '0;
      else if (run_len != RUN_MAX)
        run_len <= run_len + 1'b1;
      q <= en ? qual : src;
    end
  end
endmodule

// File: rtl/deadband_pair.sv
module deadband_pair
  import deadband_pkg::*;
#(
  parameter int DLY_W = DB_DLY_W_DEF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pwm_in,
  input  logic [DLY_W-1:0] rise_dly,
  input  logic [DLY_W-1:0] fall_dly,
  input  logic             en_a,
  input  logic             en_b,
  output logic             out_a,
  output logic             out_b
);
  logic [DB_NCH-1:0] chan_src;
  logic [DB_NCH-1:0] chan_en;
  logic [DB_NCH-1:0] chan_q;
  logic [DLY_W-1:0]  chan_dly [DB_NCH];

  db_source_split u_split (
    .pwm_in   (pwm_in),
    .chan_src (chan_src)
  );

  always_comb begin
    chan_dly[DB_CH_HI] = rise_dly;
    chan_dly[DB_CH_LO] = fall_dly;
    chan_en            = '0;
    chan_en[DB_CH_HI]  = en_a;
    chan_en[DB_CH_LO]  = en_b;
  end

  for (genvar c = 0; c < DB_NCH; c++) begin : g_chan
    db_onset_delay #(.DLY_W(DLY_W)) u_dly (
      .clk (clk),
      .rst (rst),
      .src (chan_src[c]),
      .dly (chan_dly[c]),
      .en  (chan_en[c]),
      .q   (chan_q[c])
    );
  end

  assign out_a = chan_q[DB_CH_HI];
  assign out_b = chan_q[DB_CH_LO];
endmodule

// File: rtl/deadband_pair_chk.sv
module deadband_pair_chk #(
  parameter int DLY_W = 14
) (
  input logic             clk,
  input logic             rst,
  input logic             pwm_in,
  input logic [DLY_W-1:0] rise_dly,
  input logic [DLY_W-1:0] fall_dly,
  input logic             en_a,
  input logic             en_b,
  input logic             out_a,
  input logic             out_b
);
  AST_RESET_LOW: assert property (@(posedge clk) rst |=> (!out_a && !out_b)); // R1
  AST_A_OFF_FAST: assert property (@(posedge clk) disable iff (rst)
    (en_a && !pwm_in) |=> !out_a); // R2
  AST_B_OFF_FAST: assert property (@(posedge clk) disable iff (rst)
    (en_b && pwm_in) |=> !out_b); // R3
  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (rst)
    !(out_a && out_b)); // R4
  AST_A_ZERO_DLY: assert property (@(posedge clk) disable iff (rst)
    (en_a && rise_dly == '0) |=> (out_a == $past(pwm_in))); // R6
  AST_B_ZERO_DLY: assert property (@(posedge clk) disable iff (rst)
    (en_b && fall_dly == '0) |=> (out_b == !$past(pwm_in))); // R6
  AST_A_BYPASS: assert property (@(posedge clk) disable iff (rst)
    !en_a |=> (out_a == $past(pwm_in))); // R7
  AST_B_BYPASS: assert property (@(posedge clk) disable iff (rst)
    !en_b |=> (out_b == !$past(pwm_in))); // R8
endmodule

bind deadband_pair deadband_pair_chk #(.DLY_W(DLY_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .pwm_in   (pwm_in),
  .rise_dly (rise_dly),
  .fall_dly (fall_dly),
  .en_a     (en_a),
  .en_b     (en_b),
  .out_a    (out_a),
  .out_b    (out_b)
);

// File: tb/deadband_pair_tb.sv
module deadband_pair_tb;
  localparam int DW = 14;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          pwm = 1'b0;
  logic [DW-1:0] rise = '0;
  logic [DW-1:0] fall = '0;
  logic          en_a = 1'b1;
  logic          en_b = 1'b1;
  logic          out_a, out_b;

  int    n_chk = 0;
  int    n_err = 0;
  int    cyc   = 0;
  string tag   = "R1";

  always #4 clk = ~clk;

  deadband_pair #(.DLY_W(DW)) u_dut (
    .clk(clk), .rst(rst), .pwm_in(pwm), .rise_dly(rise), .fall_dly(fall),
    .en_a(en_a), .en_b(en_b), .out_a(out_a), .out_b(out_b)
  );

  // Behavioural reference: remembers the index of the last edge at which
  // each output's source was inactive, and compares run length with delay.
  int   last_lo_a = 0;
  int   last_lo_b = 0;
  logic exp_a = 1'b0;
  logic exp_b = 1'b0;
  bit   model_ok = 1'b0;

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      last_lo_a = cyc;
      last_lo_b = cyc;
      exp_a = 1'b0;
      exp_b = 1'b0;
    end else begin
      if (!pwm) last_lo_a = cyc;
      if (pwm)  last_lo_b = cyc;
      exp_a = en_a ? (pwm  && ((cyc - last_lo_a) > int'(rise))) : pwm;
      exp_b = en_b ? (!pwm && ((cyc - last_lo_b) > int'(fall))) : !pwm;
    end
    model_ok = 1'b1;
  end

  always @(negedge clk) begin
    if (model_ok) begin
      n_chk++;
      if (out_a !== exp_a) begin
        n_err++;
        $display("FAIL %s out_a cycle %0d actual=%b expected=%b", tag, cyc, out_a, exp_a);
      end
      n_chk++;
      if (out_b !== exp_b) begin
        n_err++;
        $display("FAIL %s out_b cycle %0d actual=%b expected=%b", tag, cyc, out_b, exp_b);
      end
      n_chk++;
      if (out_a === 1'b1 && out_b === 1'b1) begin
        n_err++;
        $display("FAIL R4 overlap cycle %0d actual=11 expected=not both high", cyc);
      end
    end
    if (cyc > 150000) begin
      n_err++;
      $display("FAIL watchdog cycle %0d actual=running expected=finished", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
      $finish;
    end
  end

  task automatic hold(input logic v, input int cycles);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      pwm = v;
    end
  endtask

  task automatic train(input int hi, input int lo, input int reps);
    for (int r = 0; r < reps; r++) begin
      hold(1'b1, hi);
      hold(1'b0, lo);
    end
  endtask

  task automatic setup(input string t, input int rd, input int fd,
                       input logic ea, input logic eb);
    @(negedge clk);
    tag  = t;
    pwm  = 1'b0;
    rise = DW'(rd);
    fall = DW'(fd);
    en_a = ea;
    en_b = eb;
  endtask

  initial begin
    // R1: reset holds both drives low
    repeat (4) @(negedge clk);
    tag = "R2/R3";
    rst = 1'b0;
    // R2, R3, R4: typical 15-cycle dead time on both edges
    setup("R2/R3", 15, 15, 1'b1, 1'b1);
    train(60, 60, 3);
    train(16, 17, 2);
    // R10: unequal settings stay independent
    setup("R10", 3, 20, 1'b1, 1'b1);
    train(40, 40, 3);
    setup("R10", 25, 2, 1'b1, 1'b1);
    train(40, 40, 3);
    // R5: runt pulses and pulses equal to the delay are swallowed
    setup("R5", 10, 10, 1'b1, 1'b1);
    hold(1'b0, 30);
    train(5, 30, 2);
    train(10, 30, 2);
    train(11, 30, 1);
    train(40, 5, 2);
    train(40, 10, 2);
    train(40, 11, 1);
    // R6: zero delay gives one-cycle latency
    setup("R6", 0, 0, 1'b1, 1'b1);
    train(1, 1, 6);
    train(3, 2, 4);
    // R7: bypass on A only
    setup("R7", 12, 12, 1'b0, 1'b1);
    train(2, 30, 3);
    train(30, 30, 2);
    // R8: bypass on B only
    setup("R8", 12, 12, 1'b1, 1'b0);
    train(30, 2, 3);
    train(30, 30, 2);
    // R9: largest 14-bit delay
    setup("R9", 16383, 16383, 1'b1, 1'b1);
    train(16400, 16400, 1);
    // R1: reset in the middle of activity
    setup("R1", 2, 2, 1'b1, 1'b1);
    hold(1'b1, 10);
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    tag = "R2/R3";
    hold(1'b1, 10);
    hold(1'b0, 10);
    @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end
endmodule